// File: doc/BRIEF.md
# Configuration State Sequencer

This block steers a programmable logic device from power-up to user operation. It moves through four phases: memory clear, the wait for the shared init line, configuration, and start-up, after which the device runs. It drives the pull-down of the open-drain, wire-ANDed init line, a pair of complementary busy status outputs and the finished output. It runs a clear handshake with an external memory-clear engine, latches the mode inputs and compares a configuration cycle counter against a loaded length value. Abort and reconfiguration requests come from two active-low request pins, and the rules for them differ by phase.

The analog power-on detector is replaced by an asynchronous `pwr_good` input. It passes through a synchronizer with asynchronous assertion and synchronous release, and it clears the whole sequencer. The init line is sampled through a two-flop synchronizer. Bitstream contents are not decoded. The block sees only a per-cycle count enable, an end-of-configuration frame flag and a bit-error flag.

Top module: `cfg_seq_top`

## Requirements
- R1: While `pwr_good` is low, and at any moment it falls, the block is in the clear phase at once. In that phase `init_pull_low`=1, `cfg_finished`=0, `busy_hi`=1, `busy_lo`=0, `dout_en`=0, `io_en`=0 and `usr_rst_n`=0. Release of `pwr_good` takes effect after two rising clock edges.
- R2: In the clear phase `init_pull_low` is 1. `clr_req` is 1 and the block stays in the clear phase until `clr_done` is sampled high. When `keep_cfg`=1 and a configuration has already completed since power-up, `clr_req` stays 0 and the clear phase lasts exactly one cycle.
- R3: After the clear phase, `init_pull_low` is 0. The block stays out of configuration while the synchronized init line is low, or while `abort_n` or `reprog_n` is low. A low cycle on the line, or a low on either pin, restarts the count of high cycles.
- R4: When bit 0 of `mode_in` is 0 (slave), configuration starts once the synchronized line has been high, with both pins high, for 2 consecutive cycles. This is the 4th rising edge after `init_sense` rises. `mode_latched` captures `mode_in` at that edge and holds it through configuration.
- R5: When bit 0 of `mode_in` is 1 (master), 6 more cycles are needed, 8 in total. Configuration starts on the 10th rising edge after `init_sense` rises.
- R6: During configuration `busy_hi`=1, `busy_lo`=0, `init_pull_low`=0, `dout_en`=1 and `cfg_finished`=0.
- R7: The length counter is cleared on entry to configuration and counts each cycle in which `cfg_tick` is 1. `len_load` stores `len_value` in any phase. Configuration completes on the edge after the counter equals the stored length while `eoc_frame` is 1. A match without `eoc_frame`, or `eoc_frame` without a match, does not complete it.
- R8: During configuration, `abort_n`=0 or `reprog_n`=0 returns the block to the clear phase on the next edge. This takes precedence over completion in the same cycle.
- R9: During configuration, `bit_err`=1 returns the block to the clear phase on the next edge. This also takes precedence over completion.
- R10: Start-up sets `cfg_finished`=1 and `io_en`=1, with `busy_hi`=0 and `busy_lo`=1. It holds `usr_rst_n`=0 for 3 cycles and then enters operation with `usr_rst_n`=1.
- R11: In start-up and operation `abort_n` has no effect. `reprog_n`=0 returns the block to the clear phase on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sequencer clock |
| pwr_good | input | 1 | Asynchronous power-good, low clears the block |
| init_sense | input | 1 | Level of the wire-ANDed init line |
| init_pull_low | output | 1 | Enables the open-drain pull-down of the init line |
| abort_n | input | 1 | Active-low abort request, honoured only before start-up |
| reprog_n | input | 1 | Active-low reprogram request |
| mode_in | input | MODE_W (4) | Mode inputs, bit 0 selects master |
| keep_cfg | input | 1 | Skip the memory clear on reconfiguration |
| clr_req | output | 1 | Request to the memory-clear engine |
| clr_done | input | 1 | Memory clear finished |
| len_load | input | 1 | Store `len_value` as the length count |
| len_value | input | LEN_W (16) | Configuration length in counted cycles |
| cfg_tick | input | 1 | Counts one configuration cycle |
| eoc_frame | input | 1 | End-of-configuration frame has been written |
| bit_err | input | 1 | Bit error seen in the configuration stream |
| busy_hi | output | 1 | High while not yet started up |
| busy_lo | output | 1 | Low while not yet started up |
| cfg_finished | output | 1 | Start-up reached |
| dout_en | output | 1 | Serial data-out enable, active during configuration |
| io_en | output | 1 | User I/O enable |
| usr_rst_n | output | 1 | Internal user reset, released in operation |
| mode_latched | output | MODE_W (4) | Mode captured at configuration entry |

## Verification
Length completion and abort can meet in one cycle. So can completion and a bit error. In each case the counter has reached the stored length with `eoc_frame` high, and the abort or error arrives in that same cycle. The bench counts the length out, then raises `eoc_frame` together with `abort_n` low in one cycle, and in a later run together with `bit_err`. It judges the result one edge later: the block must be back in the clear phase with `cfg_finished` low, never in start-up.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
   typedef enum logic [2:0] {
      ST_CLEAR  = 3'd0,
      ST_WAIT   = 3'd1,
      ST_CONFIG = 3'd2,
      ST_START  = 3'd3,
      ST_OPER   = 3'd4
   } cfg_state_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain <= RST_VAL;
            else         chain <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain <= {STAGES{RST_VAL}};
            else         chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_len_cnt.sv
module cfg_len_cnt #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             eoc,
   output logic             match
);
   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         len_q <= '1;
      end else begin
         if (load) len_q <= load_val;
         if (clear)     cnt <= '0;
         else if (tick) cnt <= cnt + 1'b1;
      end
   end

   assign match = eoc && (cnt == len_q);
endmodule

// File: rtl/cfg_fsm.sv
module cfg_fsm
   import cfg_seq_pkg::*;
#(
   parameter int MODE_W       = 4,
   parameter int MASTER_BIT   = 0,
   parameter int INIT_HI_CYC  = 2,
   parameter int MASTER_EXTRA = 6,
   parameter int STARTUP_CYC  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_s,
   input  logic              abort_n,
   input  logic              reprog_n,
   input  logic [MODE_W-1:0] mode_in,
   input  logic              keep_cfg,
   input  logic              clr_done,
   input  logic              bit_err,
   input  logic              len_match,
   output cfg_state_e        state,
   output logic              cfg_enter,
   output logic              clr_req,
   output logic [MODE_W-1:0] mode_latched
);
   localparam int MAX_WAIT = INIT_HI_CYC + MASTER_EXTRA;
   localparam int TW       = $clog2(MAX_WAIT + 1);
   localparam int SW       = $clog2(STARTUP_CYC + 1);

   cfg_state_e  nxt;
   logic [TW-1:0] hi_cnt;
   logic [TW-1:0] need_m1;
   logic [SW-1:0] st_cnt;
   logic          cfged;
   logic          pins_ok;
   logic          skip_clr;
   logic          stop_cfg;
   logic          wait_go;

   assign need_m1  = mode_in[MASTER_BIT] ? TW'(MAX_WAIT - 1) : TW'(INIT_HI_CYC - 1);
   assign pins_ok  = abort_n && reprog_n;
   assign skip_clr = keep_cfg && cfged;
   assign stop_cfg = !pins_ok || bit_err;
   assign wait_go  = init_s && pins_ok && (hi_cnt == need_m1);

   always_comb begin
      nxt = state;
      unique case (state)
         ST_CLEAR:  if (skip_clr || clr_done) nxt = ST_WAIT;
         ST_WAIT:   if (wait_go) nxt = ST_CONFIG;
         ST_CONFIG: begin
            if (stop_cfg)       nxt = ST_CLEAR;
            else if (len_match) nxt = ST_START;
         end
         ST_START: begin
            if (!reprog_n)                          nxt = ST_CLEAR;
            else if (st_cnt == SW'(STARTUP_CYC - 1)) nxt = ST_OPER;
         end
         ST_OPER:   if (!reprog_n) nxt = ST_CLEAR;
         default:   nxt = ST_CLEAR;
      endcase
   end

   assign cfg_enter = (state == ST_WAIT) && wait_go;
   assign clr_req   = (state == ST_CLEAR) && !skip_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_CLEAR;
         hi_cnt       <= '0;
         st_cnt       <= '0;
         cfged        <= 1'b0;
         mode_latched <= '0;
      end else begin
         state <= nxt;
         if (state == ST_WAIT && init_s && pins_ok && !wait_go) hi_cnt <= hi_cnt + 1'b1;
         else                                                   hi_cnt <= '0;
         if (state == ST_START && nxt == ST_START) st_cnt <= st_cnt + 1'b1;
         else                                      st_cnt <= '0;
         if (state == ST_CONFIG && nxt == ST_START) cfged <= 1'b1;
         if (cfg_enter) mode_latched <= mode_in;
      end
   end
endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
   import cfg_seq_pkg::*;
#(
   parameter int MODE_W       = 4,
   parameter int MASTER_BIT   = 0,
   parameter int LEN_W        = 16,
   parameter int SYNC_STAGES  = 2,
   parameter int INIT_HI_CYC  = 2,
   parameter int MASTER_EXTRA = 6,
   parameter int STARTUP_CYC  = 3
) (
   input  logic              clk,
   input  logic              pwr_good,
   input  logic              init_sense,
   output logic              init_pull_low,
   input  logic              abort_n,
   input  logic              reprog_n,
   input  logic [MODE_W-1:0] mode_in,
   input  logic              keep_cfg,
   output logic              clr_req,
   input  logic              clr_done,
   input  logic              len_load,
   input  logic [LEN_W-1:0]  len_value,
   input  logic              cfg_tick,
   input  logic              eoc_frame,
   input  logic              bit_err,
   output logic              busy_hi,
   output logic              busy_lo,
   output logic              cfg_finished,
   output logic              dout_en,
   output logic              io_en,
   output logic              usr_rst_n,
   output logic [MODE_W-1:0] mode_latched
);
   generate
      if (MASTER_BIT >= MODE_W) begin : g_bad_mode
         $error("MASTER_BIT must index a mode input");
      end
      if (INIT_HI_CYC < 1 || STARTUP_CYC < 1 || SYNC_STAGES < 1) begin : g_bad_cyc
         $error("cycle counts and synchronizer depth must be at least 1");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("LEN_W must be at least 1");
      end
   endgenerate

   logic       sys_rst_n;
   logic       init_s;
   logic       len_match;
   logic       cfg_enter;
   cfg_state_e state;

   cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_pwr_sync (
      .clk(clk), .arst_n(pwr_good), .d(1'b1), .q(sys_rst_n));

   cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_init_sync (
      .clk(clk), .arst_n(sys_rst_n), .d(init_sense), .q(init_s));

   cfg_len_cnt #(.LEN_W(LEN_W)) i_len (
      .clk(clk), .rst_n(sys_rst_n), .clear(cfg_enter),
      .tick(cfg_tick && (state == ST_CONFIG)),
      .load(len_load), .load_val(len_value), .eoc(eoc_frame), .match(len_match));

   cfg_fsm #(
      .MODE_W(MODE_W), .MASTER_BIT(MASTER_BIT), .INIT_HI_CYC(INIT_HI_CYC),
      .MASTER_EXTRA(MASTER_EXTRA), .STARTUP_CYC(STARTUP_CYC)
   ) i_fsm (
      .clk(clk), .rst_n(sys_rst_n), .init_s(init_s), .abort_n(abort_n),
      .reprog_n(reprog_n), .mode_in(mode_in), .keep_cfg(keep_cfg),
      .clr_done(clr_done), .bit_err(bit_err), .len_match(len_match),
      .state(state), .cfg_enter(cfg_enter), .clr_req(clr_req),
      .mode_latched(mode_latched));

   assign init_pull_low = (state == ST_CLEAR);
   assign busy_hi       = (state == ST_CLEAR) || (state == ST_WAIT) || (state == ST_CONFIG);
   assign busy_lo       = !busy_hi;
   assign dout_en       = (state == ST_CONFIG);
   assign cfg_finished  = (state == ST_START) || (state == ST_OPER);
   assign io_en         = cfg_finished;
   assign usr_rst_n     = (state == ST_OPER);
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk #(
   parameter int MODE_W = 4
) (
   input logic              clk,
   input logic              sys_rst_n,
   input logic              init_s,
   input logic              abort_n,
   input logic              reprog_n,
   input logic              bit_err,
   input logic              clr_req,
   input logic              clr_done,
   input logic              init_pull_low,
   input logic              busy_hi,
   input logic              busy_lo,
   input logic              cfg_finished,
   input logic              dout_en,
   input logic              io_en,
   input logic              usr_rst_n,
   input logic [MODE_W-1:0] mode_latched
);
   p_pwr_low_r1: assert property (@(posedge clk)
      !sys_rst_n |-> (init_pull_low && !cfg_finished && !dout_en));

   p_clear_hold_r2: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (clr_req && !clr_done) |=> init_pull_low);

   p_init_low_wait_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (!init_pull_low && !dout_en && !cfg_finished && !init_s) |=> !dout_en);

   p_mode_hold_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (dout_en && $past(dout_en)) |-> $stable(mode_latched));

   p_cfg_outputs_r6: assert property (@(posedge clk) disable iff (!sys_rst_n)
      dout_en |-> (busy_hi && !busy_lo && !cfg_finished && !init_pull_low));

   p_abort_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (dout_en && (!abort_n || !reprog_n)) |=> (init_pull_low && !cfg_finished));

   p_bit_err_r9: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (dout_en && bit_err) |=> (init_pull_low && !cfg_finished));

   p_startup_r10: assert property (@(posedge clk) disable iff (!sys_rst_n)
      $rose(usr_rst_n) |-> (cfg_finished && io_en && !busy_hi && busy_lo));

   p_run_hold_r11: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (cfg_finished && reprog_n) |=> cfg_finished);

   p_reprog_r11: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (cfg_finished && !reprog_n) |=> (init_pull_low && !cfg_finished));
endmodule

bind cfg_seq_top cfg_seq_chk #(.MODE_W(MODE_W)) i_cfg_seq_chk (
   .clk(clk), .sys_rst_n(sys_rst_n), .init_s(init_s), .abort_n(abort_n),
   .reprog_n(reprog_n), .bit_err(bit_err), .clr_req(clr_req), .clr_done(clr_done),
   .init_pull_low(init_pull_low), .busy_hi(busy_hi), .busy_lo(busy_lo),
   .cfg_finished(cfg_finished), .dout_en(dout_en), .io_en(io_en),
   .usr_rst_n(usr_rst_n), .mode_latched(mode_latched));

// File: tb/test_cfg_seq_top.sv
`timescale 1ns/1ps
module test_cfg_seq_top;
   logic        clk = 1'b0;
   logic        pwr_good = 1'b0;
   logic        ext_hi = 1'b1;
   logic        init_sense;
   logic        init_pull_low;
   logic        abort_n = 1'b1;
   logic        reprog_n = 1'b1;
   logic [3:0]  mode_in = 4'h0;
   logic        keep_cfg = 1'b0;
   logic        clr_req;
   logic        clr_done = 1'b0;
   logic        len_load = 1'b0;
   logic [15:0] len_value = 16'd0;
   logic        cfg_tick = 1'b0;
   logic        eoc_frame = 1'b0;
   logic        bit_err = 1'b0;
   logic        busy_hi, busy_lo, cfg_finished, dout_en, io_en, usr_rst_n;
   logic [3:0]  mode_latched;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 1'b0;

   always #4 clk = ~clk;

   assign init_sense = ext_hi & ~init_pull_low;

   cfg_seq_top i_cfg_seq_top (
      .clk(clk), .pwr_good(pwr_good), .init_sense(init_sense), .init_pull_low(init_pull_low),
      .abort_n(abort_n), .reprog_n(reprog_n), .mode_in(mode_in), .keep_cfg(keep_cfg),
      .clr_req(clr_req), .clr_done(clr_done), .len_load(len_load), .len_value(len_value),
      .cfg_tick(cfg_tick), .eoc_frame(eoc_frame), .bit_err(bit_err), .busy_hi(busy_hi),
      .busy_lo(busy_lo), .cfg_finished(cfg_finished), .dout_en(dout_en), .io_en(io_en),
      .usr_rst_n(usr_rst_n), .mode_latched(mode_latched));

   // mode[15:12], length[11:4], expected edges from init release to configuration [3:0]
   localparam logic [15:0] VEC [4] = '{
      {4'h1, 8'd7, 4'd10},
      {4'h0, 8'd3, 4'd4},
      {4'h7, 8'd0, 4'd10},
      {4'hA, 8'd1, 4'd4}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic power_up();
      @(negedge clk);
      pwr_good = 1'b0; ext_hi = 1'b1; abort_n = 1'b1; reprog_n = 1'b1;
      clr_done = 1'b0; cfg_tick = 1'b0; eoc_frame = 1'b0; bit_err = 1'b0;
      keep_cfg = 1'b0; len_load = 1'b0;
      cyc(3);
      pwr_good = 1'b1;
      cyc(3);
   endtask

   task automatic load_len(input int v);
      len_value = 16'(v);
      len_load  = 1'b1;
      cyc(1);
      len_load  = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         cfg_tick = 1'b1;
         cyc(1);
      end
      cfg_tick = 1'b0;
   endtask

   task automatic wait_cfg(input string req);
      int n = 0;
      while (!dout_en && n < 40) begin
         cyc(1);
         n++;
      end
      check(dout_en == 1'b1, req, int'(dout_en), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: outputs during power-good low
      cyc(2);
      check(init_pull_low && !cfg_finished && busy_hi && !busy_lo && !dout_en && !io_en && !usr_rst_n,
            "R1 power reset state", int'({init_pull_low, cfg_finished, busy_hi, dout_en, io_en, usr_rst_n}), 6'b101000);

      for (int i = 0; i < 4; i++) begin
         int n;
         int lat;
         int ln;
         power_up();
         check(clr_req && init_pull_low, "R2 clear request after power-up", int'({clr_req, init_pull_low}), 3);
         mode_in = VEC[i][15:12];
         ln      = int'(VEC[i][11:4]);
         lat     = int'(VEC[i][3:0]);
         load_len(ln);
         cyc(4);
         check(init_pull_low == 1'b1, "R2 clear held without done", int'(init_pull_low), 1);
         clr_done = 1'b1;
         @(posedge clk); @(negedge clk);
         clr_done = 1'b0;
         check(init_pull_low == 1'b0, "R2 init released after clear", int'(init_pull_low), 0);
         n = 0;
         while (!dout_en && n < 40) begin
            cyc(1);
            n++;
         end
         check(n == lat, mode_in[0] ? "R5 master entry latency" : "R4 slave entry latency", n, lat);
         check(mode_latched == VEC[i][15:12], "R4 mode latched", int'(mode_latched), int'(VEC[i][15:12]));
         check(busy_hi && !busy_lo && !cfg_finished && !init_pull_low, "R6 config outputs",
               int'({busy_hi, busy_lo, cfg_finished, init_pull_low}), 4'b1000);
         eoc_frame = 1'b1;
         ticks(ln);
         check(cfg_finished == 1'b0, "R7 completion one edge after match", int'(cfg_finished), 0);
         cyc(1);
         check(cfg_finished == 1'b1, "R7 completion on length match", int'(cfg_finished), 1);
         eoc_frame = 1'b0;
         check(io_en && !busy_hi && busy_lo && !usr_rst_n, "R10 start-up outputs",
               int'({io_en, busy_hi, busy_lo, usr_rst_n}), 4'b1010);
         cyc(2);
         check(usr_rst_n == 1'b0, "R10 internal reset held", int'(usr_rst_n), 0);
         cyc(1);
         check(usr_rst_n == 1'b1, "R10 internal reset released", int'(usr_rst_n), 1);
      end

      // R11: abort pin ignored in operation
      abort_n = 1'b0;
      cyc(5);
      check(cfg_finished && usr_rst_n, "R11 abort ignored in operation", int'({cfg_finished, usr_rst_n}), 3);
      abort_n = 1'b1;
      // R11: reprogram returns to clear
      reprog_n = 1'b0;
      cyc(1);
      check(init_pull_low && !cfg_finished, "R11 reprogram restarts", int'({init_pull_low, cfg_finished}), 2);
      check(clr_req == 1'b1, "R2 clear requested without keep", int'(clr_req), 1);
      // R2: keep option skips the clear
      keep_cfg = 1'b1;
      #1;
      check(clr_req == 1'b0, "R2 no clear request with keep", int'(clr_req), 0);
      cyc(1);
      check(init_pull_low == 1'b0, "R2 skip clear in one cycle", int'(init_pull_low), 0);
      // R3: reprogram pin held low blocks configuration
      mode_in = 4'h0;
      cyc(15);
      check(dout_en == 1'b0, "R3 held by reprog pin", int'(dout_en), 0);
      reprog_n = 1'b1;
      cyc(1);
      check(dout_en == 1'b0, "R4 two high cycles needed", int'(dout_en), 0);
      cyc(1);
      check(dout_en == 1'b1, "R4 entry after two high cycles", int'(dout_en), 1);

      // R8: abort pin during configuration
      abort_n = 1'b0;
      cyc(1);
      check(init_pull_low && !dout_en, "R8 abort pin in config", int'({init_pull_low, dout_en}), 2);
      cyc(10);
      check(dout_en == 1'b0, "R3 held by abort pin", int'(dout_en), 0);
      abort_n = 1'b1;
      cyc(2);
      check(dout_en == 1'b1, "R3 resumes after abort released", int'(dout_en), 1);

      // R9: bit error
      bit_err = 1'b1;
      cyc(1);
      bit_err = 1'b0;
      check(init_pull_low && !dout_en, "R9 bit error in config", int'({init_pull_low, dout_en}), 2);
      wait_cfg("R9 reconfigure after error");

      // R7: end frame without match, match without end frame
      load_len(2);
      eoc_frame = 1'b1;
      cyc(3);
      check(dout_en && !cfg_finished, "R7 end frame without match", int'(cfg_finished), 0);
      eoc_frame = 1'b0;
      ticks(2);
      cyc(3);
      check(dout_en && !cfg_finished, "R7 match without end frame", int'(cfg_finished), 0);
      eoc_frame = 1'b1;
      cyc(1);
      check(cfg_finished == 1'b1, "R7 end frame completes", int'(cfg_finished), 1);
      eoc_frame = 1'b0;

      // same-cycle completion and abort
      reprog_n = 1'b0;
      cyc(1);
      reprog_n = 1'b1;
      wait_cfg("R11 reconfigure");
      ticks(2);
      eoc_frame = 1'b1;
      abort_n = 1'b0;
      cyc(1);
      check(init_pull_low && !cfg_finished, "R8 abort beats completion", int'({init_pull_low, cfg_finished}), 2);
      eoc_frame = 1'b0;
      abort_n = 1'b1;
      wait_cfg("R8 reconfigure after abort");
      ticks(2);
      eoc_frame = 1'b1;
      bit_err = 1'b1;
      cyc(1);
      check(init_pull_low && !cfg_finished, "R9 error beats completion", int'({init_pull_low, cfg_finished}), 2);
      eoc_frame = 1'b0;
      bit_err = 1'b0;

      // R5: master count restarted by single low cycles
      mode_in = 4'h1;
      ext_hi  = 1'b1;
      begin
         bit got = 1'b0;
         for (int r = 0; r < 6; r++) begin
            for (int k = 0; k < 4; k++) begin
               cyc(1);
               got |= dout_en;
            end
            ext_hi = 1'b0;
            cyc(1);
            got |= dout_en;
            ext_hi = 1'b1;
         end
         check(got == 1'b0, "R5 low blips restart master count", int'(got), 0);
      end
      wait_cfg("R5 master entry after steady high");

      // R1: power-good drop in operation
      load_len(0);
      eoc_frame = 1'b1;
      cyc(5);
      eoc_frame = 1'b0;
      check(usr_rst_n == 1'b1, "R10 operation reached", int'(usr_rst_n), 1);
      pwr_good = 1'b0;
      #1;
      check(init_pull_low && !cfg_finished && !usr_rst_n, "R1 asynchronous power loss",
            int'({init_pull_low, cfg_finished, usr_rst_n}), 4);

      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule